// File: doc/BRIEF.md
# RGMII Link-Speed Bring-Up Sequencer

This block is a hardware state machine that reprograms an RGMII I/O macro whenever a new link speed is requested. A single-cycle `start` pulse samples a two-bit speed code. The sequencer then walks a fixed program of register updates into a local register file of six configuration words and one read-only status word. It first restores the power-on contents and turns on the function clock. Next it cycles the DLL through reset and power-down. At gigabit only, it enables the DLL, waits for lock and runs the clock-data-recovery calibration. Finally it applies the pad and delay settings that belong to the chosen speed.

Every register update is a read-modify-write: one cycle reads the word and the next cycle writes `(old & ~clear) | set`. Poll steps read a word and compare masked bits against an expected value. Each poll is retried up to `POLL_LIMIT` times. A poll that runs out of retries raises a sticky timeout flag, and the sequence still continues to the end. The six configuration words leave the block as ports that feed the analog macro. DLL lock enters as a modelled input bit and appears in the status word.

Top module: `rgmii_speed_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `tmo` are 0 and all six configuration words are 0.
- R2: A `start` sampled while idle raises `busy` on the next cycle. When the program ends, `busy` falls and `done` is high for exactly one cycle, in the first idle cycle.
- R3: A `start` pulse that arrives while `busy` is ignored. The run does not restart, `done` pulses only once, and the final words are those of the first request.
- R4: Speed code 2'b10 (1000 Mb/s) with lock present ends with these words: main 0x40C01347, DLL 0x000F6400, delay 0x80000039, DLL2 0x00006807, user 0x04010800, aux 0x000000A0.
- R5: Speed code 2'b01 (100 Mb/s) ends with these words: main 0x4040134D, DLL 0x0004642C, delay 0x6FE00000, DLL2 0x00200000, user 0x00010800, aux 0x00000020.
- R6: Speed code 2'b00 (10 Mb/s) ends with these words: main 0x4040134D, DLL 0x0004642C, delay 0x6FE00000, DLL2 0x00200000, user 0x00010800, aux 0x00000000. Aux bit 5 (TX clock phase shift) is the bit that separates this case from 100 Mb/s.
- R7: Speed code 2'b11 raises `err` together with `done`. It applies only the power-on restore, function-clock enable, DLL reset cycling, loopback clear and interface-select clear. The words end as main 0x40C01343, DLL 0x0004642C, delay 0, DLL2 0x00200000, user 0x00010800, aux 0x00000060.
- R8: At 1000 Mb/s with the lock bit (status bit 7) held low, the lock wait runs `POLL_LIMIT` polls of two cycles each. It then sets `tmo` and still finishes with `done` and the same words as R4.
- R9: `err` and `tmo` stay set after `done` and clear only when the next `start` is accepted.
- R10: At 100 and 10 Mb/s there is no lock wait, so a low `dll_lock` never raises `tmo`.
- R11: While idle, the configuration words do not change, whatever `dll_lock` and `speed` do.
- R12: The speed code is captured at the accepted `start`. Changing `speed` during a run has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; samples `speed` when idle |
| speed | input | 2 | 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s, 11 = invalid |
| dll_lock | input | 1 | Modelled DLL lock, read back as status bit 7 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky: last request had an invalid speed code |
| tmo | output | 1 | Sticky: a poll exhausted its retries in the last run |
| cfg_main | output | 32 | Main macro configuration word |
| cfg_dll | output | 32 | DLL configuration word |
| cfg_ddr | output | 32 | Receive/transmit delay word |
| cfg_dll2 | output | 32 | Second DLL configuration word |
| cfg_usr | output | 32 | User-control word |
| cfg_aux | output | 32 | Second macro configuration word |

## Verification
The hardest case to reach is the lock timeout, because a healthy DLL input always satisfies the poll on the first read. The bench holds `dll_lock` low through a whole gigabit run. It then checks three things: the run lasts at least two cycles per allowed poll, `tmo` rises, and the calibration writes after the wait still land. A second hard case is a start that collides with a running sequence. The bench fires a different request a few cycles into a gigabit run and checks that exactly one `done` pulse follows and that the words keep gigabit values.

// File: rtl/rgsq_pkg.sv
package rgsq_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int NUM_CFG  = 6;
    localparam int LOCK_BIT = 7;
    localparam int N_STEPS  = 45;
    localparam int STEP_W   = $clog2(N_STEPS + 1);

    typedef enum logic [ADDR_W-1:0] {
        RA_MAIN = 3'd0,
        RA_DLL  = 3'd1,
        RA_DDR  = 3'd2,
        RA_DLL2 = 3'd3,
        RA_USR  = 3'd4,
        RA_AUX  = 3'd5,
        RA_STAT = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        SPD_10  = 2'b00,
        SPD_100 = 2'b01,
        SPD_1G  = 2'b10,
        SPD_BAD = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        OP_SKIP = 2'd0,
        OP_RMW  = 2'd1,
        OP_POLL = 2'd2,
        OP_END  = 2'd3
    } op_e;

    // For OP_POLL, clr is the compare mask and set is the expected value.
    typedef struct packed {
        op_e               op;
        reg_addr_e         addr;
        logic [WORD_W-1:0] clr;
        logic [WORD_W-1:0] set;
    } step_t;

    localparam logic [WORD_W-1:0] POR_MAIN = 32'h00C0_1343;
    localparam logic [WORD_W-1:0] POR_DLL  = 32'h2004_642C;
    localparam logic [WORD_W-1:0] POR_DDR  = 32'h0000_0000;
    localparam logic [WORD_W-1:0] POR_DLL2 = 32'h0020_0000;
    localparam logic [WORD_W-1:0] POR_USR  = 32'h0001_0800;
    localparam logic [WORD_W-1:0] POR_AUX  = 32'h0000_2060;

    function automatic logic [WORD_W-1:0] bm(input int n);
        return 32'h1 << n;
    endfunction

    function automatic logic [WORD_W-1:0] fm(input int hi, input int lo);
        return ((32'h1 << (hi - lo + 1)) - 32'h1) << lo;
    endfunction

    function automatic step_t mk(input op_e o, input reg_addr_e a,
                                 input logic [WORD_W-1:0] c,
                                 input logic [WORD_W-1:0] s);
        step_t t;
        t.op   = o;
        t.addr = a;
        t.clr  = c;
        t.set  = s;
        return t;
    endfunction

    function automatic step_t rmw(input reg_addr_e a,
                                  input logic [WORD_W-1:0] c,
                                  input logic [WORD_W-1:0] s);
        return mk(OP_RMW, a, c, s);
    endfunction

    // The full bring-up program, indexed by step; speed decides which
    // steps are live and which values they carry.
    function automatic step_t prog_step(input int unsigned idx, input speed_e spd);
        step_t s;
        logic  gig;
        logic  bad;
        logic  ten;
        gig = (spd == SPD_1G);
        bad = (spd == SPD_BAD);
        ten = (spd == SPD_10);
        s   = mk(OP_SKIP, RA_MAIN, '0, '0);
        case (idx)
            // power-on restore, then function clock on
            0:  s = rmw(RA_MAIN, '1, POR_MAIN);
            1:  s = rmw(RA_DLL,  '1, POR_DLL);
            2:  s = rmw(RA_DDR,  '1, POR_DDR);
            3:  s = rmw(RA_DLL2, '1, POR_DLL2);
            4:  s = rmw(RA_USR,  '1, POR_USR);
            5:  s = rmw(RA_AUX,  '1, POR_AUX);
            6:  s = rmw(RA_MAIN, '0, bm(30));
            // DLL reset / power-down cycling
            7:  s = rmw(RA_DLL, '0, bm(30));
            8:  s = rmw(RA_DLL, '0, bm(29));
            9:  s = rmw(RA_DLL, bm(30), '0);
            10: s = rmw(RA_DLL, bm(29), '0);
            // gigabit DLL enable and lock wait
            11: if (gig) s = rmw(RA_DLL, '0, bm(16));
            12: if (gig) s = rmw(RA_DLL, '0, bm(18));
            13: if (gig) s = rmw(RA_USR, fm(26, 24), bm(26));
            14: if (gig) s = mk(OP_POLL, RA_STAT, bm(LOCK_BIT), bm(LOCK_BIT));
            // gigabit calibration
            15: if (gig) s = rmw(RA_DLL, '0, bm(17));
            16: if (gig) s = rmw(RA_DLL, '0, bm(19));
            17: if (gig) s = rmw(RA_DLL, bm(18), '0);
            18: if (gig) s = rmw(RA_DLL, '0, bm(16));
            19: if (gig) s = rmw(RA_DLL, bm(5), '0);
            20: if (gig) s = rmw(RA_DLL, fm(3, 2), '0);
            21: if (gig) s = mk(OP_POLL, RA_DLL, bm(18), '0);
            22: if (gig) s = rmw(RA_DLL, '0, bm(18));
            23: if (gig) s = mk(OP_POLL, RA_DLL, bm(18), bm(18));
            24: if (gig) s = rmw(RA_DLL2, '0, bm(0));
            25: if (gig) s = rmw(RA_DLL2, bm(21), '0);
            26: if (gig) s = rmw(RA_DLL2, fm(17, 10), 32'h1A << 10);
            27: if (gig) s = rmw(RA_DLL2, fm(3, 2), bm(2));
            28: if (gig) s = rmw(RA_DLL2, '0, bm(1));
            // common to every request
            29: s = rmw(RA_AUX,  bm(13), '0);
            30: s = rmw(RA_MAIN, fm(5, 4), '0);
            // speed-specific section
            31: if (!bad) s = rmw(RA_MAIN, '0, bm(0));
            32: if (!bad) s = gig ? rmw(RA_MAIN, bm(3), '0) : rmw(RA_MAIN, '0, bm(3));
            33: if (!bad) s = gig ? rmw(RA_MAIN, '0, bm(23)) : rmw(RA_MAIN, bm(23), '0);
            34: if (!bad) s = gig ? rmw(RA_MAIN, '0, bm(1)) : rmw(RA_MAIN, bm(1), '0);
            35: if (!bad && !gig)
                    s = ten ? rmw(RA_MAIN, fm(16, 8), 32'h13 << 8)
                            : rmw(RA_MAIN, fm(7, 6), bm(6));
            36: if (!bad) s = rmw(RA_AUX, bm(6), '0);
            37: if (!bad) s = ten ? rmw(RA_AUX, bm(5), '0) : rmw(RA_AUX, '0, bm(5));
            38: if (!bad) s = rmw(RA_AUX, fm(31, 17), '0);
            39: if (!bad) s = gig ? rmw(RA_AUX, '0, bm(7)) : rmw(RA_AUX, bm(7), '0);
            40: if (!bad) s = gig ? rmw(RA_DDR, fm(8, 0), 32'd57)
                                  : rmw(RA_DDR, fm(29, 27), 32'd5 << 27);
            41: if (!bad) s = gig ? rmw(RA_DDR, '0, bm(31)) : rmw(RA_DDR, '0, fm(26, 21));
            42: if (!bad && !gig) s = rmw(RA_DDR, '0, bm(30));
            43: if (!bad) s = rmw(RA_MAIN, '0, bm(2));
            default: s = mk(OP_END, RA_MAIN, '0, '0);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rgsq_regfile.sv
module rgsq_regfile
    import rgsq_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [WORD_W-1:0]               wr_data,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [WORD_W-1:0]               rd_data,
    input  logic                            lock_in,
    output logic [NUM_CFG-1:0][WORD_W-1:0]  words
);

    logic [NUM_CFG-1:0][WORD_W-1:0] word_q;
    logic [WORD_W-1:0]              stat_word;

    always_comb begin
        stat_word           = '0;
        stat_word[LOCK_BIT] = lock_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CFG; i++) begin
                if (wr_en && wr_addr == ADDR_W'(i)) begin
                    word_q[i] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (rd_addr == RA_STAT) begin
                rd_data <= stat_word;
            end else if (int'(rd_addr) < NUM_CFG) begin
                rd_data <= word_q[rd_addr];
            end else begin
                rd_data <= '0;
            end
        end
    end

    assign words = word_q;

endmodule

// File: rtl/rgsq_poll_timer.sv
module rgsq_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expired
);

    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign expired = tick && (cnt_q == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: the retry count never passes the configured bound
    assert_poll_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(LIMIT - 1));

endmodule

// File: rtl/rgsq_ctrl.sv
module rgsq_ctrl
    import rgsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         speed,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [WORD_W-1:0]  wr_data,
    output logic               poll_tick,
    output logic               poll_clr,
    input  logic               poll_expired,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               tmo
);

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_WRITE = 3'd2,
        S_CHECK = 3'd3,
        S_FIN   = 3'd4
    } state_e;

    state_e            state_q;
    logic [STEP_W-1:0] idx_q;
    speed_e            spd_q;
    step_t             cur;
    logic              hit;

    assign cur  = prog_step(int'(idx_q), spd_q);
    assign hit  = ((rd_data & cur.clr) == cur.set);
    assign busy = (state_q != S_IDLE);

    always_comb begin
        rd_en     = (state_q == S_FETCH) && (cur.op == OP_RMW || cur.op == OP_POLL);
        rd_addr   = cur.addr;
        wr_en     = (state_q == S_WRITE);
        wr_addr   = cur.addr;
        wr_data   = (rd_data & ~cur.clr) | cur.set;
        poll_tick = (state_q == S_CHECK) && !hit;
        poll_clr  = ((state_q == S_IDLE) && start) || ((state_q == S_CHECK) && hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            spd_q   <= SPD_10;
            done    <= 1'b0;
            err     <= 1'b0;
            tmo     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        spd_q   <= speed_e'(speed);
                        idx_q   <= '0;
                        err     <= 1'b0;
                        tmo     <= 1'b0;
                        state_q <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    case (cur.op)
                        OP_SKIP: idx_q   <= idx_q + 1'b1;
                        OP_RMW:  state_q <= S_WRITE;
                        OP_POLL: state_q <= S_CHECK;
                        default: state_q <= S_FIN;
                    endcase
                end
                S_WRITE: begin
                    idx_q   <= idx_q + 1'b1;
                    state_q <= S_FETCH;
                end
                S_CHECK: begin
                    if (hit) begin
                        idx_q <= idx_q + 1'b1;
                    end else if (poll_expired) begin
                        tmo   <= 1'b1;
                        idx_q <= idx_q + 1'b1;
                    end
                    state_q <= S_FETCH;
                end
                S_FIN: begin
                    err     <= (spd_q == SPD_BAD);
                    done    <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R2: completion pulse comes right after the busy period
    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R3: a run never moves backwards through its program
    assert_idx_forward_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (idx_q >= $past(idx_q)));

    // R12: captured speed is frozen for the whole run
    assert_spd_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(spd_q));

    // R7: the error flag only rises for the unsupported code
    assert_err_bad_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (spd_q == SPD_BAD));

    // R10: only the gigabit path has polls that can time out
    assert_tmo_gig_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo) |-> (spd_q == SPD_1G));

endmodule

// File: rtl/rgmii_speed_seq.sv
module rgmii_speed_seq
    import rgsq_pkg::*;
#(
    parameter int POLL_LIMIT = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  speed,
    input  logic        dll_lock,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        tmo,
    output logic [31:0] cfg_main,
    output logic [31:0] cfg_dll,
    output logic [31:0] cfg_ddr,
    output logic [31:0] cfg_dll2,
    output logic [31:0] cfg_usr,
    output logic [31:0] cfg_aux
);

    logic                           rd_en;
    logic                           wr_en;
    logic [ADDR_W-1:0]              rd_addr;
    logic [ADDR_W-1:0]              wr_addr;
    logic [WORD_W-1:0]              rd_data;
    logic [WORD_W-1:0]              wr_data;
    logic                           poll_tick;
    logic                           poll_clr;
    logic                           poll_expired;
    logic [NUM_CFG-1:0][WORD_W-1:0] words;

    rgsq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .speed        (speed),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .poll_tick    (poll_tick),
        .poll_clr     (poll_clr),
        .poll_expired (poll_expired),
        .busy         (busy),
        .done         (done),
        .err          (err),
        .tmo          (tmo)
    );

    rgsq_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (poll_clr),
        .tick    (poll_tick),
        .expired (poll_expired)
    );

    rgsq_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .lock_in (dll_lock),
        .words   (words)
    );

    assign cfg_main = words[RA_MAIN];
    assign cfg_dll  = words[RA_DLL];
    assign cfg_ddr  = words[RA_DDR];
    assign cfg_dll2 = words[RA_DLL2];
    assign cfg_usr  = words[RA_USR];
    assign cfg_aux  = words[RA_AUX];

    // R11: nothing reaches the macro words while the sequencer is idle
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(cfg_main) && $stable(cfg_dll) && $stable(cfg_ddr) &&
                   $stable(cfg_dll2) && $stable(cfg_usr) && $stable(cfg_aux)));

endmodule

// File: tb/rgmii_speed_seq_test.sv
`timescale 1ns/1ps
module rgmii_speed_seq_test;

    localparam int LIMIT = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  speed = 2'b00;
    logic        dll_lock = 1'b1;
    logic        busy, done, err, tmo;
    logic [31:0] cfg_main, cfg_dll, cfg_ddr, cfg_dll2, cfg_usr, cfg_aux;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rgmii_speed_seq #(.POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .start(start), .speed(speed), .dll_lock(dll_lock),
        .busy(busy), .done(done), .err(err), .tmo(tmo),
        .cfg_main(cfg_main), .cfg_dll(cfg_dll), .cfg_ddr(cfg_ddr),
        .cfg_dll2(cfg_dll2), .cfg_usr(cfg_usr), .cfg_aux(cfg_aux)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_words(input string tag, input logic [31:0] m, input logic [31:0] d,
                             input logic [31:0] y, input logic [31:0] d2,
                             input logic [31:0] u, input logic [31:0] a);
        chk({tag, " main"}, cfg_main, m);
        chk({tag, " dll"},  cfg_dll,  d);
        chk({tag, " ddr"},  cfg_ddr,  y);
        chk({tag, " dll2"}, cfg_dll2, d2);
        chk({tag, " usr"},  cfg_usr,  u);
        chk({tag, " aux"},  cfg_aux,  a);
    endtask

    // Pulse start at a negedge, then wait for done; returns busy length.
    task automatic run_seq(input logic [1:0] spd, output int cycles);
        @(negedge clk);
        speed = spd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", {31'b0, busy}, 32'd1);
        cycles = 1;
        while (!done && cycles < 20000) begin
            @(negedge clk);
            cycles++;
        end
        chk("R2 done seen", {31'b0, done}, 32'd1);
        chk("R2 busy low at done", {31'b0, busy}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 err",  {31'b0, err},  32'd0);
        chk("R1 tmo",  {31'b0, tmo},  32'd0);
        chk_words("R1", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_gig();
        int n;
        dll_lock = 1'b1;
        run_seq(2'b10, n);
        chk_words("R4", 32'h40C01347, 32'h000F6400, 32'h80000039,
                  32'h00006807, 32'h04010800, 32'h000000A0);
        chk("R4 tmo", {31'b0, tmo}, 32'd0);
        @(negedge clk);
        chk("R2 done one cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic t_100();
        int n;
        dll_lock = 1'b0;
        run_seq(2'b01, n);
        chk_words("R5", 32'h4040134D, 32'h0004642C, 32'h6FE00000,
                  32'h00200000, 32'h00010800, 32'h00000020);
        chk("R10 no tmo at 100", {31'b0, tmo}, 32'd0);
    endtask

    task automatic t_10();
        int n;
        dll_lock = 1'b0;
        run_seq(2'b00, n);
        chk_words("R6", 32'h4040134D, 32'h0004642C, 32'h6FE00000,
                  32'h00200000, 32'h00010800, 32'h00000000);
        chk("R10 no tmo at 10", {31'b0, tmo}, 32'd0);
    endtask

    task automatic t_bad();
        int n;
        dll_lock = 1'b1;
        run_seq(2'b11, n);
        chk("R7 err", {31'b0, err}, 32'd1);
        chk_words("R7", 32'h40C01343, 32'h0004642C, 32'h00000000,
                  32'h00200000, 32'h00010800, 32'h00000060);
        repeat (5) @(negedge clk);
        chk("R9 err sticky", {31'b0, err}, 32'd1);
    endtask

    task automatic t_timeout();
        int n;
        dll_lock = 1'b0;
        run_seq(2'b10, n);
        chk("R8 tmo", {31'b0, tmo}, 32'd1);
        chk("R8 run length", {31'b0, (n >= 2 * LIMIT)}, 32'd1);
        chk_words("R8", 32'h40C01347, 32'h000F6400, 32'h80000039,
                  32'h00006807, 32'h04010800, 32'h000000A0);
        repeat (3) @(negedge clk);
        chk("R9 tmo sticky", {31'b0, tmo}, 32'd1);
        dll_lock = 1'b1;
        @(negedge clk);
        speed = 2'b01;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 tmo cleared by start", {31'b0, tmo}, 32'd0);
        while (!done) @(negedge clk);
    endtask

    task automatic t_err_clear();
        int n;
        run_seq(2'b01, n);
        chk("R9 err cleared", {31'b0, err}, 32'd0);
    endtask

    task automatic t_restart_ignored();
        int dones = 0;
        dll_lock = 1'b1;
        @(negedge clk);
        speed = 2'b10;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        speed = 2'b00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk("R3 single done", dones, 32'd1);
        chk_words("R3", 32'h40C01347, 32'h000F6400, 32'h80000039,
                  32'h00006807, 32'h04010800, 32'h000000A0);
    endtask

    task automatic t_speed_change();
        int n = 0;
        dll_lock = 1'b1;
        @(negedge clk);
        speed = 2'b00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        speed = 2'b10;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk("R12 aux follows captured 10", cfg_aux, 32'h00000000);
        chk("R12 dll follows captured 10", cfg_dll, 32'h0004642C);
    endtask

    task automatic t_idle_hold();
        logic [31:0] m, a;
        m = cfg_main;
        a = cfg_aux;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            dll_lock = ~dll_lock;
            speed = 2'(i);
        end
        chk("R11 main held", cfg_main, m);
        chk("R11 aux held", cfg_aux, a);
        chk("R11 still idle", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gig();
        t_100();
        t_10();
        t_bad();
        t_err_clear();
        t_timeout();
        t_restart_ignored();
        t_speed_change();
        t_idle_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule